// File: doc/BRIEF.md
# Graphics Command Queue with Register Read-Back

This block buffers commands on their way to a graphics engine. Each command carries a 3-bit subchannel, an 11-bit method offset and a 32-bit parameter. Commands enter through a valid/ready push stream and leave through a valid/ready pop stream in arrival order. The put and get pointers are kept in Gray code. The slot that a command lands in is the Gray value itself, not the binary count, so consecutive commands land in slots 0, 1, 3, 2, 6, and so on.

A registered read port lets software inspect any queue slot, the two pointers and a separate single-entry side cache. An address decodes into the slot to read and into the half of the entry to return. The side cache takes writes in two steps. A method/subchannel word is staged first, and a data word then commits both halves together.

Back-pressure rules: `push_ready` is low while the queue is full. A command offered while `push_ready` is low is not stored. It sets the sticky `overflow` flag, and the source may keep offering it. `pop_valid` is high whenever the queue holds a command. While `pop_ready` is low, the pop outputs hold their values.

Top module: `gfx_cmd_queue`

## Requirements
- R1: After reset the queue is empty, `pop_valid`, `overflow` and `rd_valid` are low, both pointer registers read 0 and every slot reads 0.
- R2: A push is taken when `push_valid` and `push_ready` are both high. Its subchannel, method and parameter are written unchanged into the slot whose index equals the current put Gray value. Pops return the commands in push order.
- R3: The put pointer register reads as the Gray-coded slot index shifted left by 2. Each accepted push replaces the Gray value g with gray(bin(g)+1), wrapping modulo the depth, so exactly one bit changes.
- R4: The get pointer uses the same encoding. It advances only when `pop_valid` and `pop_ready` are both high.
- R5: The queue is full when advancing put would make it equal to get, so it holds at most depth−1 commands. While full, `push_ready` is low and an offered command is not stored. Any such offer sets `overflow`, which stays high until reset.
- R6: `pop_valid` is high exactly when put differs from get. The pop outputs show the slot at the get pointer and stay stable while `pop_ready` is low.
- R7: A read with address bit 11 = 0 targets a queue slot. The slot index is address bits [3 +: 6], or [3 +: 5] when the small depth is chosen. Address bit 2 = 1 returns the 32-bit parameter of that slot.
- R8: A read with address bit 2 = 0 returns a method word: method in bits 10:0, subchannel in bits 15:13, all other bits 0.
- R9: Read data is registered. `rd_data` and `rd_valid` reflect a request in the cycle after `rd_en`, and `rd_valid` is low in the cycle after a cycle without `rd_en`.
- R10: A side-cache write with `sc_wr_data_sel` = 0 stages bits 10:0 as the method and bits 15:13 as the subchannel. Reads do not show the staged value. A write with `sc_wr_data_sel` = 1 commits the staged pair together with the written 32-bit data.
- R11: Address bit 11 = 1 and bit 3 = 0 reads the committed side-cache entry, with bit 2 selecting the data or the method word as in R7/R8. Bit 11 = 1 and bit 3 = 1 reads the put pointer register (bit 2 = 0) or the get pointer register (bit 2 = 1).
- R12: In the queue region, address bits between the slot field and bit 11, and address bits 1:0, have no effect on the value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Command offered |
| push_ready | output | 1 | Queue can take a command (not full) |
| push_subch | input | 3 | Subchannel of the offered command |
| push_method | input | 11 | Method offset of the offered command |
| push_param | input | 32 | Parameter of the offered command |
| pop_valid | output | 1 | A command is waiting |
| pop_ready | input | 1 | Consumer takes the command |
| pop_subch | output | 3 | Subchannel at the get pointer |
| pop_method | output | 11 | Method offset at the get pointer |
| pop_param | output | 32 | Parameter at the get pointer |
| overflow | output | 1 | Sticky: a command was offered while full |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 12 | Register read address |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read data |
| sc_wr_en | input | 1 | Side-cache write strobe |
| sc_wr_data_sel | input | 1 | 0: method/subchannel word, 1: data word (commit) |
| sc_wr_data | input | 32 | Side-cache write data |

## Verification
The hardest state to reach is a full queue whose pointers have already wrapped. In that state the slot written next is a Gray index deep in the sequence, and overflow and stalled pops meet at the same time. The stimulus first fills the queue with pops held off, then drains it. After that it runs long random phases that switch between a heavy push bias and a heavy pop bias. These phases carry the pointers around the ring many times and hit full and empty repeatedly. Register reads with random addresses, including the ignored alias bits, are mixed into those phases, so slot contents are checked at Gray positions as they change.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;
  localparam int SUBCH_W   = 3;
  localparam int METH_W    = 11;
  localparam int PARAM_W   = 32;
  localparam int SUBCH_LSB = 13;

  typedef struct packed {
    logic [SUBCH_W-1:0] subch;
    logic [METH_W-1:0]  meth;
    logic [PARAM_W-1:0] param;
  } cmd_entry_t;

  // Combined method/subchannel word as seen on the read port.
  function automatic logic [31:0] method_word(input logic [SUBCH_W-1:0] s,
                                              input logic [METH_W-1:0] m);
    logic [31:0] w;
    w = '0;
    w[METH_W-1:0] = m;
    w[SUBCH_LSB +: SUBCH_W] = s;
    return w;
  endfunction
endpackage

// File: rtl/gcq_gray_ptr.sv
module gcq_gray_ptr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] gray_q,
  output logic [IDX_W-1:0] gray_nxt
);
  logic [IDX_W-1:0] bin_cur;
  logic [IDX_W-1:0] bin_inc;

  // Prefix XOR from the top bit down.
  for (genvar i = 0; i < IDX_W; i++) begin : g_g2b
    assign bin_cur[i] = ^gray_q[IDX_W-1:i];
  end

  assign bin_inc  = bin_cur + IDX_W'(1);
  assign gray_nxt = bin_inc ^ (bin_inc >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gray_q <= '0;
    else if (adv) gray_q <= gray_nxt;
  end

  assert_gray_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> $countones(gray_q ^ $past(gray_q)) == 1);

  assert_gray_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(gray_q));
endmodule

// File: rtl/gcq_slot_store.sv
module gcq_slot_store
  import gfx_cmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cmd_entry_t       wr_entry,
  input  logic [IDX_W-1:0] pop_idx,
  output cmd_entry_t       pop_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output cmd_entry_t       rd_entry
);
  // Fields kept in separate arrays so no field can spill into another.
  logic [SUBCH_W-1:0] sub_mem  [DEPTH];
  logic [METH_W-1:0]  meth_mem [DEPTH];
  logic [PARAM_W-1:0] par_mem  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sub_mem[g]  <= '0;
        meth_mem[g] <= '0;
        par_mem[g]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        sub_mem[g]  <= wr_entry.subch;
        meth_mem[g] <= wr_entry.meth;
        par_mem[g]  <= wr_entry.param;
      end
    end
  end

  always_comb begin
    pop_entry.subch = sub_mem[pop_idx];
    pop_entry.meth  = meth_mem[pop_idx];
    pop_entry.param = par_mem[pop_idx];
    rd_entry.subch  = sub_mem[rd_idx];
    rd_entry.meth   = meth_mem[rd_idx];
    rd_entry.param  = par_mem[rd_idx];
  end
endmodule

// File: rtl/gcq_side_cache.sv
module gcq_side_cache
  import gfx_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_data_sel,
  input  logic [31:0] wr_data,
  output cmd_entry_t  entry
);
  logic [SUBCH_W-1:0] stg_subch;
  logic [METH_W-1:0]  stg_meth;
  logic               commit;

  assign commit = wr_en && wr_data_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_subch <= '0;
      stg_meth  <= '0;
      entry     <= '0;
    end else if (wr_en) begin
      if (!wr_data_sel) begin
        stg_meth  <= wr_data[METH_W-1:0];
        stg_subch <= wr_data[SUBCH_LSB +: SUBCH_W];
      end else begin
        entry.subch <= stg_subch;
        entry.meth  <= stg_meth;
        entry.param <= wr_data;
      end
    end
  end

  assert_side_commit_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(entry));
endmodule

// File: rtl/gfx_cmd_queue.sv
module gfx_cmd_queue
  import gfx_cmd_pkg::*;
#(
  parameter bit LARGE_QUEUE = 1'b1,
  parameter int ADDR_W      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  output logic               push_ready,
  input  logic [SUBCH_W-1:0] push_subch,
  input  logic [METH_W-1:0]  push_method,
  input  logic [PARAM_W-1:0] push_param,
  output logic               pop_valid,
  input  logic               pop_ready,
  output logic [SUBCH_W-1:0] pop_subch,
  output logic [METH_W-1:0]  pop_method,
  output logic [PARAM_W-1:0] pop_param,
  output logic               overflow,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  input  logic               sc_wr_en,
  input  logic               sc_wr_data_sel,
  input  logic [31:0]        sc_wr_data
);
  localparam int IDX_W = LARGE_QUEUE ? 6 : 5;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] put_g, put_g_nxt, get_g, get_g_nxt;
  logic             full, empty, push_fire, pop_fire;
  cmd_entry_t       in_entry, head_entry, rd_entry, side_entry;
  logic [IDX_W-1:0] rd_slot;
  logic [31:0]      rd_mux;
  logic             unused_addr_bits;

  assign empty      = (put_g == get_g);
  assign full       = (put_g_nxt == get_g);
  assign push_ready = !full;
  assign pop_valid  = !empty;
  assign push_fire  = push_valid && !full;
  assign pop_fire   = pop_valid && pop_ready;

  assign in_entry.subch = push_subch;
  assign in_entry.meth  = push_method;
  assign in_entry.param = push_param;

  gcq_gray_ptr #(.IDX_W(IDX_W)) u_put_ptr (
    .clk(clk), .rst_n(rst_n), .adv(push_fire), .gray_q(put_g), .gray_nxt(put_g_nxt)
  );

  gcq_gray_ptr #(.IDX_W(IDX_W)) u_get_ptr (
    .clk(clk), .rst_n(rst_n), .adv(pop_fire), .gray_q(get_g), .gray_nxt(get_g_nxt)
  );

  gcq_slot_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_fire), .wr_idx(put_g), .wr_entry(in_entry),
    .pop_idx(get_g), .pop_entry(head_entry),
    .rd_idx(rd_slot), .rd_entry(rd_entry)
  );

  gcq_side_cache u_side (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sc_wr_en), .wr_data_sel(sc_wr_data_sel), .wr_data(sc_wr_data),
    .entry(side_entry)
  );

  assign pop_subch  = head_entry.subch;
  assign pop_method = head_entry.meth;
  assign pop_param  = head_entry.param;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (push_valid && full) overflow <= 1'b1;
  end

  // Read decode: bit ADDR_W-1 picks queue slots or side cache/pointers.
  assign rd_slot = rd_addr[3 +: IDX_W];
  assign unused_addr_bits = ^{rd_addr[1:0], rd_addr[ADDR_W-2:3+IDX_W], get_g_nxt};

  always_comb begin
    if (!rd_addr[ADDR_W-1]) begin
      rd_mux = rd_addr[2] ? rd_entry.param : method_word(rd_entry.subch, rd_entry.meth);
    end else if (!rd_addr[3]) begin
      rd_mux = rd_addr[2] ? side_entry.param : method_word(side_entry.subch, side_entry.meth);
    end else begin
      rd_mux = 32'(rd_addr[2] ? get_g : put_g) << 2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_full_blocks_put_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop_fire |=> put_g == $past(put_g));

  assert_pop_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !pop_ready && !push_fire |=> pop_valid && $stable(pop_param) && $stable(pop_method) && $stable(pop_subch));

  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: tb/test_gfx_cmd_queue.sv
`timescale 1ns/1ps
module test_gfx_cmd_queue;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic push_valid, push_ready, pop_valid, pop_ready, overflow;
  logic [2:0] push_subch, pop_subch;
  logic [10:0] push_method, pop_method;
  logic [31:0] push_param, pop_param;
  logic rd_en, rd_valid;
  logic [11:0] rd_addr;
  logic [31:0] rd_data;
  logic sc_wr_en, sc_wr_data_sel;
  logic [31:0] sc_wr_data;

  gfx_cmd_queue i_gfx_cmd_queue (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_subch(push_subch), .push_method(push_method), .push_param(push_param),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_subch(pop_subch), .pop_method(pop_method), .pop_param(pop_param),
    .overflow(overflow),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .sc_wr_en(sc_wr_en), .sc_wr_data_sel(sc_wr_data_sel), .sc_wr_data(sc_wr_data)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  // Reference model
  logic [2:0]  m_sub [DEPTH];
  logic [10:0] m_meth[DEPTH];
  logic [31:0] m_par [DEPTH];
  int put_b = 0, get_b = 0, cnt = 0;
  bit ovf = 0;
  logic [2:0] s_stg_s = 0, s_com_s = 0;
  logic [10:0] s_stg_m = 0, s_com_m = 0;
  logic [31:0] s_com_d = 0;
  bit rd_pend = 0;
  logic [31:0] rd_exp = 0;
  string rd_tag = "R9";

  function automatic int b2g(int b);
    return (b ^ (b >> 1)) & (DEPTH - 1);
  endfunction

  function automatic logic [31:0] mword(logic [2:0] s, logic [10:0] m);
    return {16'h0, s, 2'b00, m};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a, output string tag);
    int idx;
    if (!a[11]) begin
      idx = int'(a[8:3]);
      tag = a[2] ? "R7" : "R8";
      return a[2] ? m_par[idx] : mword(m_sub[idx], m_meth[idx]);
    end else if (!a[3]) begin
      tag = "R11";
      return a[2] ? s_com_d : mword(s_com_s, s_com_m);
    end else begin
      tag = a[2] ? "R4" : "R3";
      return 32'(a[2] ? b2g(get_b) : b2g(put_b)) << 2;
    end
  endfunction

  // Model one clock edge using currently driven inputs, then check at the falling edge.
  task automatic tick();
    bit f0, e0;
    int slot;
    rd_pend = rd_en;
    if (rd_en) rd_exp = exp_read(rd_addr, rd_tag);
    f0 = (cnt == DEPTH - 1);
    e0 = (cnt == 0);
    if (push_valid && f0) ovf = 1;
    if (pop_ready && !e0) begin
      get_b = (get_b + 1) % DEPTH; cnt--;
    end
    if (push_valid && !f0) begin
      slot = b2g(put_b);
      m_sub[slot] = push_subch; m_meth[slot] = push_method; m_par[slot] = push_param;
      put_b = (put_b + 1) % DEPTH; cnt++;
    end
    if (sc_wr_en) begin
      if (sc_wr_data_sel) begin
        s_com_s = s_stg_s; s_com_m = s_stg_m; s_com_d = sc_wr_data;
      end else begin
        s_stg_m = sc_wr_data[10:0]; s_stg_s = sc_wr_data[15:13];
      end
    end
    @(negedge clk);
    chk("R6 pop_valid", 32'(pop_valid), 32'(cnt != 0));
    chk("R5 push_ready", 32'(push_ready), 32'(cnt != DEPTH - 1));
    chk("R5 overflow", 32'(overflow), 32'(ovf));
    if (cnt != 0) begin
      slot = b2g(get_b);
      chk("R2 pop_param", pop_param, m_par[slot]);
      chk("R2 pop_method", 32'(pop_method), 32'(m_meth[slot]));
      chk("R2 pop_subch", 32'(pop_subch), 32'(m_sub[slot]));
    end
    chk("R9 rd_valid", 32'(rd_valid), 32'(rd_pend));
    if (rd_pend) chk(rd_tag, rd_data, rd_exp);
  endtask

  task automatic idle();
    push_valid = 0; pop_ready = 0; rd_en = 0; sc_wr_en = 0;
  endtask

  task automatic do_read(logic [11:0] a);
    idle(); rd_en = 1; rd_addr = a; tick(); rd_en = 0;
  endtask

  task automatic do_push(logic [2:0] s, logic [10:0] m, logic [31:0] p);
    idle(); push_valid = 1; push_subch = s; push_method = m; push_param = p; tick(); push_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin
      m_sub[i] = 0; m_meth[i] = 0; m_par[i] = 0;
    end
    rst_n = 0; idle(); rd_addr = 0; push_subch = 0; push_method = 0; push_param = 0;
    sc_wr_data_sel = 0; sc_wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tick();
    do_read(12'h808);
    chk("R1 put reg after reset", rd_data, 32'h0);
    do_read(12'h80C);
    chk("R1 get reg after reset", rd_data, 32'h0);
    do_read(12'h02C);

    // R2/R3: five pushes, put register = gray(5)<<2 = 0x1C
    for (int i = 0; i < 5; i++) do_push(3'(i + 1), 11'(100 + i), 32'hA000_0000 + 32'(i));
    do_read(12'h808);
    chk("R3 put reg after 5 pushes", rd_data, 32'h1C);
    // slot 2 (gray of 3) holds the fourth push
    do_read(12'h014);
    chk("R7 slot2 param", rd_data, 32'hA000_0003);
    do_read(12'h010);
    chk("R8 slot2 method word", rd_data, {16'h0, 3'd4, 2'b00, 11'd103});
    // R12: alias bits 10:9 and 1:0 ignored
    do_read(12'h617);
    chk("R12 alias slot2 param", rd_data, 32'hA000_0003);

    // R5: fill to full with pops held off, then offer more
    for (int i = 0; i < DEPTH + 4; i++) do_push(3'(i), 11'(i * 7), $urandom);
    chk("R5 overflow set", 32'(overflow), 32'h1);
    chk("R5 queue holds depth-1", 32'(cnt), 32'(DEPTH - 1));
    // R6: stall stability over idle cycles
    idle(); tick(); tick();
    // drain fully
    idle(); pop_ready = 1;
    while (cnt != 0) tick();
    idle(); tick();
    do_read(12'h80C);
    chk("R4 get equals put after drain", rd_data, 32'(b2g(put_b)) << 2);

    // R10/R11: staged method word not visible until data word
    idle(); sc_wr_en = 1; sc_wr_data_sel = 0; sc_wr_data = {16'h0, 3'd5, 2'b11, 11'h2AB}; tick();
    idle(); do_read(12'h800);
    chk("R10 staged not visible", rd_data, 32'h0);
    idle(); sc_wr_en = 1; sc_wr_data_sel = 1; sc_wr_data = 32'hDEAD_BEEF; tick();
    idle(); do_read(12'h800);
    chk("R11 side method word", rd_data, {16'h0, 3'd5, 2'b00, 11'h2AB});
    do_read(12'h804);
    chk("R11 side data word", rd_data, 32'hDEAD_BEEF);

    // Random phases
    for (int ph = 0; ph < 24; ph++) begin
      int pp = (ph % 2 == 0) ? 85 : 20;
      int pr = (ph % 2 == 0) ? 25 : 85;
      for (int c = 0; c < 250; c++) begin
        push_valid = (($urandom % 100) < pp);
        pop_ready  = (($urandom % 100) < pr);
        push_subch = 3'($urandom); push_method = 11'($urandom); push_param = $urandom;
        rd_en = (($urandom % 4) == 0);
        rd_addr = 12'($urandom);
        sc_wr_en = (($urandom % 8) == 0);
        sc_wr_data_sel = 1'($urandom);
        sc_wr_data = $urandom;
        tick();
      end
    end
    idle(); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule